// File: doc/BRIEF.md
# Page-Mode Read Access Controller

This block models the read path of a flash-style memory that supports fast page reads. A backing array of words is split into pages of four words. The upper address bits pick a page and the two lowest word-address bits pick a word inside it. In byte mode, an extra low address input picks one half of that word. On a random access the controller fetches the whole page, which takes a long latency. Later reads whose page-select bits match the latched page finish after a short latency.

After reset the controller is in read mode straight away, with no command needed. A data-valid strobe shows when the output word belongs to the address currently applied. The data bus is driven only while chip enable and output enable are both active and an access has completed. Taking chip enable away puts the outputs in standby and drops the latched page, so the next access pays the full latency again.

Top module: `page_read_ctrl`

## Requirements
- R1: After reset, `data_valid` and `dq_oe` are 0. The first read after reset returns array data with no prior command and takes the initial latency.
- R2: The word at word address a holds a low half equal to (3*a + 23) mod 2^(DATA_W/2) and a high half equal to the bitwise inverse of a, taken modulo 2^(DATA_W/2).
- R3: A request misses when no page is latched or `addr[ADDR_W-1:2]` differs from the latched page. On a miss, `data_valid` rises INIT_LAT rising edges after the request is sampled, counting the sampling edge as the first. The page is latched when the access completes.
- R4: A request whose page-select bits match the latched page is a hit. On a hit, `data_valid` rises PAGE_LAT rising edges after the request is sampled, counting the same way as R3.
- R5: While chip enable stays active, any change of `addr`, of `byte_mode`, or of `addr_lsb` in byte mode starts a new request. A change of the page-select bits is a miss.
- R6: In word mode the output is the word selected by `addr[1:0]` within the page. In byte mode, `addr_lsb`=0 selects the low half and `addr_lsb`=1 selects the high half, and the upper half of `dq_o` is zero.
- R7: Deasserting chip enable (`ce_n`=1) invalidates the latched page, so the next access is a miss.
- R8: While `ce_n` is 1, `dq_oe` and `data_valid` are 0, whatever the level of `oe_n`.
- R9: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0 and `data_valid`=1. Whenever `dq_oe` is 0, `dq_o` is all zeros. Toggling `oe_n` does not restart an access.
- R10: `data_valid` reads 0 in the cycle after a new request is sampled. While `dq_oe` stays 1, `dq_o` holds its value.
- R11: A request replaced before it completes does not latch its page. A following request to that same page is therefore still a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| byte_mode | input | 1 | 1 selects byte reads, 0 selects word reads |
| addr | input | ADDR_W | Word address; bits [ADDR_W-1:2] select the page, bits [1:0] select the word |
| addr_lsb | input | 1 | Half-word select used in byte mode |
| dq_o | output | DATA_W | Read data, all zeros when not driven |
| dq_oe | output | 1 | Output-drive enable for the data bus |
| data_valid | output | 1 | Read data matches the applied address |

## Verification
The bench builds the block with ADDR_W=6, so the array has sixteen pages. Random addresses are drawn mostly from the page just used, which produces long runs of hits and frequent returns to a previously latched page. INIT_LAT=6 and PAGE_LAT=3 are set away from their defaults and from each other. With these values, a measured latency shows at once whether an access was treated as a hit or a miss, and an off-by-one in either counter load becomes visible. The short initial latency also leaves room to abandon a fetch after two cycles and still observe that its page was not latched.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

   localparam int unsigned PMR_PAGE_WORDS = 4;
   localparam int unsigned PMR_IDX_W      = 2;

   // content of the backing array, computed per word address
   function automatic logic [63:0] pmr_word_fn(input int unsigned a, input int unsigned half);
      logic [63:0] mask;
      logic [63:0] lo;
      logic [63:0] hi;
      mask = (64'd1 << half) - 64'd1;
      lo   = (64'(a) * 64'd3 + 64'd23) & mask;
      hi   = (~64'(a)) & mask;
      return (hi << half) | lo;
   endfunction

endpackage

// File: rtl/pmr_array.sv
module pmr_array
   import pmr_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned DEPTH  = 1 << ADDR_W,
   localparam int unsigned TAG_W  = ADDR_W - PMR_IDX_W,
   localparam int unsigned HALF   = DATA_W / 2
)(
   input  logic [TAG_W-1:0]                   page_idx,
   output logic [PMR_PAGE_WORDS*DATA_W-1:0]   page_data
);

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [63:0] CELL = pmr_word_fn(i, HALF);
      assign mem[i] = CELL[DATA_W-1:0];
   end

   for (genvar w = 0; w < PMR_PAGE_WORDS; w++) begin : g_port
      assign page_data[w*DATA_W +: DATA_W] = mem[{page_idx, PMR_IDX_W'(w)}];
   end

endmodule

// File: rtl/pmr_page_buf.sv
module pmr_page_buf
   import pmr_pkg::*;
#(
   parameter int unsigned TAG_W  = 4,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned LINE_W = PMR_PAGE_WORDS * DATA_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fill,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [LINE_W-1:0] fill_data,
   input  logic [TAG_W-1:0]  look_tag,
   output logic              hit,
   output logic [LINE_W-1:0] line
);

   logic              vld_q;
   logic [TAG_W-1:0]  tag_q;
   logic [LINE_W-1:0] line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         tag_q  <= '0;
         line_q <= '0;
      end else if (clr) begin
         vld_q  <= 1'b0;
      end else if (fill) begin
         vld_q  <= 1'b1;
         tag_q  <= fill_tag;
         line_q <= fill_data;
      end
   end

   assign hit  = vld_q && (tag_q == look_tag);
   assign line = line_q;

endmodule

// File: rtl/pmr_lat_timer.sv
module pmr_lat_timer #(
   parameter int unsigned INIT_LAT = 8,
   parameter int unsigned PAGE_LAT = 2,
   localparam int unsigned CNT_W   = $clog2(INIT_LAT + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic stop,
   input  logic start,
   input  logic long_sel,
   output logic done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || stop)
         cnt_q <= '0;
      else if (start)
         cnt_q <= long_sel ? CNT_W'(INIT_LAT - 1) : CNT_W'(PAGE_LAT - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pmr_lane_sel.sv
module pmr_lane_sel
   import pmr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   localparam int unsigned HALF   = DATA_W / 2,
   localparam int unsigned LINE_W = PMR_PAGE_WORDS * DATA_W
)(
   input  logic [LINE_W-1:0]    line,
   input  logic [PMR_IDX_W-1:0] word_idx,
   input  logic                 byte_sel,
   input  logic                 half_hi,
   output logic [DATA_W-1:0]    dout
);

   logic [DATA_W-1:0] word;

   assign word = line[word_idx*DATA_W +: DATA_W];

   always_comb begin
      if (!byte_sel)
         dout = word;
      else if (half_hi)
         dout = {{HALF{1'b0}}, word[DATA_W-1:HALF]};
      else
         dout = {{HALF{1'b0}}, word[HALF-1:0]};
   end

endmodule

// File: rtl/page_read_ctrl.sv
module page_read_ctrl
   import pmr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned INIT_LAT = 8,
   parameter int unsigned PAGE_LAT = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              byte_mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic              addr_lsb,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe,
   output logic              data_valid
);

   localparam int unsigned TAG_W  = ADDR_W - PMR_IDX_W;
   localparam int unsigned KEY_W  = ADDR_W + 2;
   localparam int unsigned LINE_W = PMR_PAGE_WORDS * DATA_W;

   if (PAGE_LAT < 2) begin : g_bad_page_lat
      $error("PAGE_LAT must be at least 2");
   end
   if (INIT_LAT <= PAGE_LAT) begin : g_bad_init_lat
      $error("INIT_LAT must exceed PAGE_LAT");
   end
   if (ADDR_W <= PMR_IDX_W || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W % 2 != 0 || DATA_W < 4 || DATA_W > 64) begin : g_bad_data
      $error("DATA_W must be even and within 4..64");
   end

   logic [KEY_W-1:0]     cur_key;
   logic [KEY_W-1:0]     key_q;
   logic                 active_q;
   logic                 new_req;
   logic                 lookup_hit;
   logic                 req_hit_q;
   logic [TAG_W-1:0]     req_tag_q;
   logic [PMR_IDX_W-1:0] req_idx_q;
   logic                 req_bm_q;
   logic                 req_lsb_q;
   logic                 valid_q;
   logic [DATA_W-1:0]    data_q;
   logic                 tmr_done;
   logic                 complete;
   logic [LINE_W-1:0]    arr_line;
   logic [LINE_W-1:0]    buf_line;
   logic [LINE_W-1:0]    src_line;
   logic [DATA_W-1:0]    lane_out;

   assign cur_key  = {byte_mode, addr, byte_mode & addr_lsb};
   assign new_req  = !ce_n && (!active_q || (cur_key != key_q));
   assign complete = !ce_n && !new_req && tmr_done;
   assign src_line = req_hit_q ? buf_line : arr_line;

   pmr_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_array (
      .page_idx  (req_tag_q),
      .page_data (arr_line)
   );

   pmr_page_buf #(
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
   ) u_page (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ce_n),
      .fill      (complete && !req_hit_q),
      .fill_tag  (req_tag_q),
      .fill_data (arr_line),
      .look_tag  (addr[ADDR_W-1:PMR_IDX_W]),
      .hit       (lookup_hit),
      .line      (buf_line)
   );

   pmr_lat_timer #(
      .INIT_LAT (INIT_LAT),
      .PAGE_LAT (PAGE_LAT)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .stop     (ce_n),
      .start    (new_req),
      .long_sel (!lookup_hit),
      .done     (tmr_done)
   );

   pmr_lane_sel #(
      .DATA_W (DATA_W)
   ) u_lane (
      .line     (src_line),
      .word_idx (req_idx_q),
      .byte_sel (req_bm_q),
      .half_hi  (req_lsb_q),
      .dout     (lane_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         key_q     <= '0;
         req_hit_q <= 1'b0;
         req_tag_q <= '0;
         req_idx_q <= '0;
         req_bm_q  <= 1'b0;
         req_lsb_q <= 1'b0;
         valid_q   <= 1'b0;
         data_q    <= '0;
      end else if (ce_n) begin
         active_q  <= 1'b0;
         valid_q   <= 1'b0;
      end else if (new_req) begin
         active_q  <= 1'b1;
         key_q     <= cur_key;
         req_hit_q <= lookup_hit;
         req_tag_q <= addr[ADDR_W-1:PMR_IDX_W];
         req_idx_q <= addr[PMR_IDX_W-1:0];
         req_bm_q  <= byte_mode;
         req_lsb_q <= addr_lsb;
         valid_q   <= 1'b0;
      end else if (complete) begin
         valid_q   <= 1'b1;
         data_q    <= lane_out;
      end
   end

   assign data_valid = valid_q && !ce_n;
   assign dq_oe      = data_valid && !oe_n;
   assign dq_o       = dq_oe ? data_q : '0;

endmodule

// File: rtl/page_read_ctrl_chk.sv
module page_read_ctrl_chk #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 16
)(
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              byte_mode,
   input logic [ADDR_W-1:0] addr,
   input logic              addr_lsb,
   input logic [DATA_W-1:0] dq_o,
   input logic              dq_oe,
   input logic              data_valid
);

   logic [ADDR_W+1:0] key;
   assign key = {byte_mode, addr, byte_mode & addr_lsb};

   a_r8_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!dq_oe && !data_valid));

   a_r9_oe_gates_bus: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (!dq_oe && dq_o == '0));

   a_r9_drive_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> data_valid);

   a_r10_drop_on_new_key: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n) && key != $past(key)) |=> !data_valid);

   a_r10_bus_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_oe && $past(dq_oe)) |-> $stable(dq_o));

   a_r7_fresh_after_standby: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> !data_valid);

endmodule

bind page_read_ctrl page_read_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .byte_mode  (byte_mode),
   .addr       (addr),
   .addr_lsb   (addr_lsb),
   .dq_o       (dq_o),
   .dq_oe      (dq_oe),
   .data_valid (data_valid)
);

// File: tb/page_read_ctrl_bench.sv
module page_read_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;
   localparam int DW         = 16;
   localparam int LAT_INIT   = 6;
   localparam int LAT_PAGE   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1;
   logic          oe_n = 1'b1;
   logic          byte_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          addr_lsb = 1'b0;
   logic [DW-1:0] dq_o;
   logic          dq_oe;
   logic          data_valid;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   logic          m_vld = 1'b0;
   logic [AW-3:0] m_tag = '0;
   logic [AW+1:0] m_key = '0;
   logic          m_act = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   page_read_ctrl #(
      .ADDR_W   (AW),
      .DATA_W   (DW),
      .INIT_LAT (LAT_INIT),
      .PAGE_LAT (LAT_PAGE)
   ) u_page_read_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .oe_n       (oe_n),
      .byte_mode  (byte_mode),
      .addr       (addr),
      .addr_lsb   (addr_lsb),
      .dq_o       (dq_o),
      .dq_oe      (dq_oe),
      .data_valid (data_valid)
   );

   function automatic logic [DW-1:0] exp_data(input logic [AW-1:0] a, input logic l, input logic b);
      logic [7:0] lo;
      logic [7:0] hi;
      lo = 8'(a * 3 + 23);
      hi = ~8'(a);
      if (!b) return {hi, lo};
      return l ? {8'h00, hi} : {8'h00, lo};
   endfunction

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // check bus state for the current oe_n, then flip oe_n and check again (R9)
   task automatic check_bus(input logic [DW-1:0] exp, input string req);
      for (int k = 0; k < 2; k++) begin
         if (!oe_n) begin
            chk(dq_oe == 1'b1, "R9", dq_oe, 1);
            chk(dq_o == exp, req, dq_o, exp);
         end else begin
            chk(dq_oe == 1'b0 && dq_o == '0, "R9", {dq_oe, dq_o}, 0);
         end
         oe_n = ~oe_n;
         #1;
      end
   endtask

   task automatic standby();
      @(negedge clk);
      ce_n = 1'b1;
      oe_n = 1'($urandom_range(1));
      #1;
      chk(dq_oe == 1'b0 && data_valid == 1'b0, "R8", {dq_oe, data_valid}, 0);
      @(negedge clk);
      chk(dq_oe == 1'b0 && data_valid == 1'b0, "R8", {dq_oe, data_valid}, 0);
      m_vld = 1'b0;
      m_act = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic l, input logic b, input string dreq);
      logic          hit;
      int            lat;
      int            n;
      logic [DW-1:0] exp;
      @(negedge clk);
      ce_n      = 1'b0;
      addr      = a;
      addr_lsb  = l;
      byte_mode = b;
      hit = m_vld && (m_tag == a[AW-1:2]);
      lat = hit ? LAT_PAGE : LAT_INIT;
      exp = exp_data(a, l, b);
      n = 0;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n == 1) chk(data_valid == 1'b0, "R10", data_valid, 0);
      end while (!data_valid && n < 40);
      if (hit) chk(n == lat, "R4", n, lat);
      else     chk(n == lat, "R3", n, lat);
      check_bus(exp, dreq);
      // output holds while nothing changes (R10)
      @(negedge clk);
      chk(data_valid == 1'b1, "R10", data_valid, 1);
      check_bus(exp, dreq);
      m_vld = 1'b1;
      m_tag = a[AW-1:2];
      m_act = 1'b1;
      m_key = {b, a, b & l};
   endtask

   initial begin
      while (cyc < 150000) @(posedge clk);
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(data_valid == 1'b0 && dq_oe == 1'b0, "R1", {data_valid, dq_oe}, 0);
      rst_n = 1'b1;
      oe_n  = 1'b0;
      @(negedge clk);
      chk(data_valid == 1'b0 && dq_oe == 1'b0, "R1", {data_valid, dq_oe}, 0);

      // R1/R2/R3: first read straight after reset
      do_read(6'd0, 1'b0, 1'b0, "R1");
      // R4/R6: hit within the page, word select
      do_read(6'd3, 1'b0, 1'b0, "R6");
      // R5: different page while chip enable held
      do_read(6'd21, 1'b0, 1'b0, "R5");
      // R6: byte mode both halves, hits
      do_read(6'd21, 1'b1, 1'b0 | 1'b1, "R6");
      do_read(6'd21, 1'b0, 1'b1, "R6");
      do_read(6'd22, 1'b0, 1'b0, "R2");
      // R7/R8: standby drops the page
      standby();
      do_read(6'd23, 1'b0, 1'b0, "R7");

      // R11: abandon a fetch, then stay in that page
      @(negedge clk);
      addr = 6'd40;
      byte_mode = 1'b0;
      repeat (2) @(negedge clk);
      chk(data_valid == 1'b0, "R11", data_valid, 0);
      do_read(6'd41, 1'b0, 1'b0, "R11");
      // a model miss above: do_read counted INIT latency for page 10 because
      // the model latched page 5 earlier, so also confirm page 10 now hits
      do_read(6'd42, 1'b0, 1'b0, "R11");

      // R2: sweep of random reads mixing hits, misses, modes and standby
      for (int i = 0; i < 300; i++) begin
         logic [AW-1:0] a;
         logic          l;
         logic          b;
         if ($urandom_range(9) == 0) standby();
         if ($urandom_range(9) < 7) a = {m_tag, 2'($urandom_range(3))};
         else                       a = AW'($urandom_range(63));
         b = 1'($urandom_range(1));
         l = 1'($urandom_range(1));
         if (m_act && {b, a, b & l} == m_key) a = a ^ 6'd1;
         oe_n = 1'($urandom_range(3) == 0);
         do_read(a, l, b, "R2");
      end
      finish_run();
   end

endmodule